// File: doc/BRIEF.md
# Card Write-Data Block Sequencer

This block runs the data phase of a card command that carries write data on a single-bit data line. Software first starts the command and waits for its response, which arrives from a separate command-line unit as strobes. It then loads payload bytes into a small transmit FIFO and arms the data phase. The sequencer frames each block as a start bit, the payload, a 16-bit CRC and an end bit. It then releases the line, reads back the card's CRC status token and follows the card's busy indication until the card lets the line go high again.

Three transfer styles are selectable. A single-block transfer ends after one block. An open-ended multiblock transfer pauses after every block and waits for software to continue or stop. A preset-count transfer sends blocks back to back until a programmed count is reached. Whenever the FIFO holds less than one full block where a block would start, the sequence suspends until software re-arms it. From a pause, a suspension or the armed state, software can end the sequence and the block pulses a request for a stop command. Every event is reported in a sticky flag register that is cleared by writing ones.

Top module: `wrdat_seq`

## Requirements
- R1: After reset, `busy`, `dat_oe`, `stop_req`, `dt_busy` and all seven `flags` bits are 0.
- R2: `data_en` has no effect while idle or while the command response is awaited. A block is sent only after `cmd_resp_ok` and a later `data_en`.
- R3: `cmd_timeout` while the response is awaited sets flags bit 0, drops `busy` and sends no block.
- R4: Each block occupies exactly 8*`blk_len`+18 cycles with `dat_oe` high. In order it carries a 0 start bit, the FIFO bytes in write order with the MSB first, the CRC (x^16+x^12+x^5+1, seed 0, over the payload bits) with the MSB first, and a 1 end bit.
- R5: The status token is sampled on the 3rd to 7th cycles after the end bit as start, three status bits and end. Only the sample sequence 0,0,1,0,1 is accepted. Any other sequence sets flags bit 5 and ends the sequence.
- R6: After an accepted token, each low sample of `dat_in` sets `dt_busy`. A high sample that follows at least one low sample clears it and sets flags bit 4. `BUSY_TMO` consecutive low samples set flags bit 6 and end the sequence.
- R7: With `mode`=0 (or 3), one block is sent, then flags bit 1 is set and the sequence ends.
- R8: With `mode`=1, flags bit 1 is set after every block and the sequence pauses. `data_en` sends the next block. `cmd_off` gives a single-cycle `stop_req` and ends the sequence.
- R9: With `mode`=2, blocks follow one another until `blk_cnt` are done, then flags bit 3 is set and the sequence ends without `stop_req`.
- R10: When fewer than `blk_len` bytes are queued where a block would start, flags bit 2 is set, nothing is sent and the sequence stays suspended with `busy` high. `data_en` retries the block and `cmd_off` stops with `stop_req`.
- R11: `busy` rises the cycle after an accepted `cmd_start` and stays high until the sequence ends.
- R12: Flag bits hold until a 1 is written to the same bit of `flag_clr`. Other bits are unaffected.
- R13: `fifo_clr` empties the FIFO while idle and is ignored at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | 0/3 single, 1 open-ended, 2 preset-count |
| blk_len | input | LEN_W | Bytes per block (1 or more) |
| blk_cnt | input | CNT_W | Block count for preset mode (1 or more) |
| cmd_start | input | 1 | Command issued strobe |
| cmd_resp_ok | input | 1 | Command response received strobe |
| cmd_timeout | input | 1 | No command response strobe |
| data_en | input | 1 | Arm/continue data phase strobe |
| cmd_off | input | 1 | End sequence strobe |
| fifo_wr | input | 1 | FIFO write strobe |
| fifo_wdata | input | 8 | FIFO write byte |
| fifo_clr | input | 1 | FIFO clear strobe (idle only) |
| flag_clr | input | 7 | Write-1-to-clear mask for flags |
| dat_in | input | 1 | Data line as seen from the card |
| dat_out | output | 1 | Data line drive value |
| dat_oe | output | 1 | Data line drive enable |
| stop_req | output | 1 | One-cycle stop command request |
| busy | output | 1 | Sequence in progress |
| dt_busy | output | 1 | Card holding data line low |
| flags | output | 7 | Sticky events: 0 timeout, 1 block done, 2 FIFO short, 3 count done, 4 busy end, 5 token error, 6 busy timeout |

## Verification
The bench sweeps all 32 token sample sequences. A design that accepted more than one of them, or misaligned the sampling window by a cycle, would raise or miss the token error on the wrong values. Card busy is swept from zero cycles up to exactly the timeout and one below it. An off-by-one counter would time out a legal busy or report busy-end when the line never went low. Block length and preset count are swept together and every frame is decoded bit by bit against a CRC computed in the bench, which exposes byte-boundary reload slips and wrong end conditions. The suspend tests starve the FIFO mid-sequence, retry while still short and clear the FIFO outside idle, to show that a design resuming early or losing queued bytes sends the wrong frames.

// File: rtl/wrdat_seq.sv
module wrdat_seq #(
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 4,
  parameter int CNT_W      = 4,
  parameter int BUSY_TMO   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic             cmd_start,
  input  logic             cmd_resp_ok,
  input  logic             cmd_timeout,
  input  logic             data_en,
  input  logic             cmd_off,
  input  logic             fifo_wr,
  input  logic [7:0]       fifo_wdata,
  input  logic             fifo_clr,
  input  logic [6:0]       flag_clr,
  input  logic             dat_in,
  output logic             dat_out,
  output logic             dat_oe,
  output logic             stop_req,
  output logic             busy,
  output logic             dt_busy,
  output logic [6:0]       flags
);
  localparam int AW     = $clog2(FIFO_DEPTH);
  localparam int TW     = LEN_W + 5;
  localparam int TMO_W  = $clog2(BUSY_TMO);
  localparam logic [AW:0] DEPTH_L = FIFO_DEPTH[AW:0];

  typedef enum logic [3:0] {S_IDLE, S_WRSP, S_ARM, S_TX, S_TURN, S_TOK, S_BSY, S_PAUSE, S_SUSP} st_t;
  st_t st, st_n;

  logic [7:0]       mem [FIFO_DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      fcnt;
  logic [TW-1:0]    tc, nd;
  logic [7:0]       sh;
  logic [15:0]      crc;
  logic [3:0]       tok;
  logic [CNT_W-1:0] bdone;
  logic [TMO_W-1:0] tmo;
  logic             low_seen, stop_n;
  logic [6:0]       fset;

  wire push     = fifo_wr && (fcnt < DEPTH_L);
  wire clr_ok   = fifo_clr && (st == S_IDLE);
  wire enough   = int'(fcnt) >= int'(blk_len);
  assign nd     = TW'({blk_len, 3'b000});
  wire in_data  = (tc != '0) && (tc <= nd);
  wire in_crc   = (tc > nd) && (tc <= nd + TW'(16));
  wire tc_last  = (tc == nd + TW'(17));
  wire [2:0] bib = tc[2:0] - 3'd1;
  wire load_b   = (st == S_TX) && ((tc == '0) || (in_data && bib == 3'd7 && tc != nd));
  wire last_blk = (bdone + 1'b1) == blk_cnt;

  assign busy   = (st != S_IDLE);
  assign dat_oe = (st == S_TX);
  assign dat_out = (st != S_TX) ? 1'b1 :
                   (tc == '0)   ? 1'b0 :
                   in_data      ? sh[7] :
                   in_crc       ? crc[15] : 1'b1;

  always_comb begin
    st_n   = st;
    fset   = '0;
    stop_n = 1'b0;
    case (st)
      S_IDLE: if (cmd_start) st_n = S_WRSP;
      S_WRSP: begin
        if (cmd_timeout) begin
          fset[0] = 1'b1;
          st_n = S_IDLE;
        end else if (cmd_resp_ok) st_n = S_ARM;
      end
      S_ARM, S_PAUSE, S_SUSP: begin
        if (cmd_off) begin
          stop_n = 1'b1;
          st_n = S_IDLE;
        end else if (data_en) begin
          if (enough) st_n = S_TX;
          else begin
            fset[2] = 1'b1;
            st_n = S_SUSP;
          end
        end
      end
      S_TX:   if (tc_last) st_n = S_TURN;
      S_TURN: if (tc == TW'(1)) st_n = S_TOK;
      S_TOK: begin
        if (tc == TW'(4)) begin
          if ({tok, dat_in} == 5'b00101) st_n = S_BSY;
          else begin
            fset[5] = 1'b1;
            st_n = S_IDLE;
          end
        end
      end
      S_BSY: begin
        if (dat_in) begin
          fset[4] = low_seen;
          case (mode)
            2'd1: begin fset[1] = 1'b1; st_n = S_PAUSE; end
            2'd2: begin
              if (last_blk) begin fset[3] = 1'b1; st_n = S_IDLE; end
              else if (enough) st_n = S_TX;
              else begin fset[2] = 1'b1; st_n = S_SUSP; end
            end
            default: begin fset[1] = 1'b1; st_n = S_IDLE; end
          endcase
        end else if (tmo == TMO_W'(BUSY_TMO - 1)) begin
          fset[6] = 1'b1;
          st_n = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= fifo_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else if (clr_ok) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (push)   wp <= wp + 1'b1;
      if (load_b) rp <= rp + 1'b1;
      fcnt <= fcnt + (AW+1)'(push) - (AW+1)'(load_b);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tc <= '0; sh <= '0; crc <= '0; tok <= '0;
      bdone <= '0; tmo <= '0; low_seen <= 1'b0; dt_busy <= 1'b0;
      flags <= '0; stop_req <= 1'b0;
    end else begin
      st       <= st_n;
      tc       <= (st_n != st) ? '0 : tc + 1'b1;
      stop_req <= stop_n;
      flags    <= (flags & ~flag_clr) | fset;
      dt_busy  <= (st_n == S_BSY) && !dat_in;
      if (load_b) sh <= mem[rp];
      else if (st == S_TX && in_data) sh <= {sh[6:0], 1'b0};
      if (st == S_TX && tc == '0) crc <= '0;
      else if (st == S_TX && in_data) crc <= {crc[14:0], 1'b0} ^ ((crc[15] ^ sh[7]) ? 16'h1021 : 16'h0000);
      else if (st == S_TX && in_crc) crc <= {crc[14:0], 1'b0};
      if (st == S_TOK) tok <= {tok[2:0], dat_in};
      if (st == S_WRSP) bdone <= '0;
      else if (st == S_BSY && dat_in) bdone <= bdone + 1'b1;
      if (st == S_BSY && !dat_in) tmo <= tmo + 1'b1;
      else tmo <= '0;
      if (st != S_BSY) low_seen <= 1'b0;
      else if (!dat_in) low_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/wrdat_seq_chk.sv
module wrdat_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic [6:0] flag_clr,
  input logic       dat_out,
  input logic       dat_oe,
  input logic       stop_req,
  input logic       busy,
  input logic       dt_busy,
  input logic [6:0] flags
);
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n) $rose(dat_oe) |-> !dat_out);
  p_drive_in_seq_r11: assert property (@(posedge clk) disable iff (!rst_n) dat_oe |-> busy);
  p_busy_cause_r11: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cmd_start));
  p_stop_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) stop_req |=> !stop_req);
  p_stop_ends_r10: assert property (@(posedge clk) disable iff (!rst_n) stop_req |-> !busy);
  p_timeout_idle_r3: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[0]) |-> !busy);
  p_count_done_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[3]) |-> (!busy && !stop_req));
  p_short_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[2]) |-> (busy && !dat_oe));
  p_card_busy_r6: assert property (@(posedge clk) disable iff (!rst_n) dt_busy |-> (busy && !dat_oe));
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr));
endmodule

bind wrdat_seq wrdat_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .flag_clr(flag_clr),
  .dat_out(dat_out), .dat_oe(dat_oe), .stop_req(stop_req), .busy(busy),
  .dt_busy(dt_busy), .flags(flags)
);

// File: tb/wrdat_seq_tb.sv
module wrdat_seq_tb;
  localparam int TMO = 20;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic [3:0] blk_len = 4'd1, blk_cnt = 4'd1;
  logic cmd_start = 0, cmd_resp_ok = 0, cmd_timeout = 0, data_en = 0, cmd_off = 0;
  logic fifo_wr = 0, fifo_clr = 0, dat_in = 1'b1;
  logic [7:0] fifo_wdata = '0;
  logic [6:0] flag_clr = '0;
  logic dat_out, dat_oe, stop_req, busy, dt_busy;
  logic [6:0] flags;

  wrdat_seq #(.FIFO_DEPTH(16), .LEN_W(4), .CNT_W(4), .BUSY_TMO(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .blk_len(blk_len), .blk_cnt(blk_cnt),
    .cmd_start(cmd_start), .cmd_resp_ok(cmd_resp_ok), .cmd_timeout(cmd_timeout),
    .data_en(data_en), .cmd_off(cmd_off), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .fifo_clr(fifo_clr), .flag_clr(flag_clr), .dat_in(dat_in), .dat_out(dat_out),
    .dat_oe(dat_oe), .stop_req(stop_req), .busy(busy), .dt_busy(dt_busy), .flags(flags));

  int nchk = 0, nfail = 0, nframes = 0, nstop = 0, cur_len = 1, fn = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic fbits [0:255];
  logic [4:0] card_tok = 5'b00101;
  int card_busy = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  task automatic check_frame();
    int L = cur_len;
    int bad = -1;
    int pos;
    logic [15:0] c = '0;
    logic [7:0] b;
    nframes++;
    if (fn != 8*L + 18) begin
      chk(0, "R4 frame length", fn, 8*L + 18);
      for (int i = 0; i < L; i++) if (exp_q.size() > 0) void'(exp_q.pop_front());
    end else begin
      if (fbits[0] !== 1'b0) bad = 0;
      for (int i = 0; i < L; i++) begin
        b = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
        for (int k = 7; k >= 0; k--) begin
          pos = 1 + 8*i + (7 - k);
          if (fbits[pos] !== b[k] && bad < 0) bad = pos;
          c = crc_step(c, b[k]);
        end
      end
      for (int k = 15; k >= 0; k--) begin
        pos = 8*L + 1 + (15 - k);
        if (fbits[pos] !== c[k] && bad < 0) bad = pos;
      end
      if (fbits[8*L + 17] !== 1'b1 && bad < 0) bad = 8*L + 17;
      chk(bad < 0, "R4 frame content, first bad bit", bad, -1);
    end
  endtask

  always @(negedge clk) begin
    if (dat_oe === 1'b1) begin
      if (fn < 256) fbits[fn] = dat_out;
      fn++;
    end else if (fn > 0) begin
      check_frame();
      fn = 0;
    end
    if (stop_req === 1'b1) nstop++;
  end

  initial begin
    logic od = 1'b0;
    forever begin
      @(negedge clk);
      if (od && dat_oe === 1'b0) begin
        repeat (2) @(negedge clk);
        for (int i = 4; i >= 0; i--) begin
          dat_in = card_tok[i];
          @(negedge clk);
        end
        if (card_busy > 0) begin
          dat_in = 1'b0;
          @(negedge clk);
          chk(dt_busy === 1'b1, "R6 dt_busy while card low", int'(dt_busy), 1);
          repeat (card_busy - 1) @(negedge clk);
        end
        dat_in = 1'b1;
      end
      od = dat_oe;
    end
  end

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_start = 1; 1: cmd_resp_ok = 1; 2: cmd_timeout = 1;
      3: data_en = 1;   4: cmd_off = 1;     default: fifo_clr = 1;
    endcase
    @(negedge clk);
    cmd_start = 0; cmd_resp_ok = 0; cmd_timeout = 0; data_en = 0; cmd_off = 0; fifo_clr = 0;
  endtask

  task automatic push_bytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fifo_wr = 1;
      fifo_wdata = 8'(seed*37 + i*11 + 5);
      exp_q.push_back(8'(seed*37 + i*11 + 5));
    end
    @(negedge clk);
    fifo_wr = 0;
  endtask

  task automatic clr_flags(input logic [6:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic start_cmd(input int md, input int len, input int bc);
    mode = 2'(md); blk_len = 4'(len); blk_cnt = 4'(bc); cur_len = len;
    pulse(0);
    repeat (2) @(negedge clk);
    pulse(1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_flag(input int bn);
    int n = 0;
    while (!flags[bn] && n < 3000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int f0, s0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(busy === 0, "R1 busy after reset", int'(busy), 0);
    chk(dat_oe === 0, "R1 dat_oe after reset", int'(dat_oe), 0);
    chk(flags === 7'd0, "R1 flags after reset", int'(flags), 0);
    chk(stop_req === 0 && dt_busy === 0, "R1 stop_req/dt_busy after reset", int'({stop_req, dt_busy}), 0);

    // R2: data_en ignored before response
    push_bytes(1, 1);
    mode = 0; blk_len = 1; blk_cnt = 1; cur_len = 1;
    f0 = nframes;
    pulse(3);
    pulse(0);
    chk(busy === 1, "R11 busy after cmd_start", int'(busy), 1);
    pulse(3);
    repeat (30) @(negedge clk);
    chk(nframes == f0 && dat_oe === 0, "R2 no frame before response", nframes - f0, 0);
    pulse(1);
    repeat (30) @(negedge clk);
    chk(nframes == f0, "R2 no frame before data_en", nframes - f0, 0);
    pulse(3);
    wait_idle();
    chk(nframes == f0 + 1, "R2 frame after data_en", nframes - f0, 1);
    chk(flags[1] === 1, "R7 block-done flag single", int'(flags[1]), 1);
    clr_flags(7'h7f);

    // R3: response timeout
    f0 = nframes;
    pulse(0);
    repeat (5) @(negedge clk);
    pulse(2);
    chk(flags[0] === 1, "R3 timeout flag", int'(flags[0]), 1);
    chk(busy === 0, "R3 busy dropped", int'(busy), 0);
    pulse(3);
    repeat (40) @(negedge clk);
    chk(nframes == f0 && exp_q.size() == 0, "R3 no data phase", nframes - f0, 0);
    clr_flags(7'h7f);
    chk(flags === 0, "R12 write-1 clears all", int'(flags), 0);

    // R4/R6/R7 sweep of length and busy
    for (int L = 1; L <= 4; L++) begin
      for (int b = 0; b <= 3; b++) begin
        card_busy = b;
        f0 = nframes; s0 = nstop;
        push_bytes(L, L*4 + b);
        start_cmd(0, L, 1);
        pulse(3);
        chk(busy === 1, "R11 busy during transfer", int'(busy), 1);
        wait_idle();
        chk(nframes == f0 + 1, "R7 single block count", nframes - f0, 1);
        chk(flags === (b > 0 ? 7'b0010010 : 7'b0000010), "R6 R7 flags after single block", int'(flags), b > 0 ? 18 : 2);
        chk(nstop == s0 && busy === 0 && dt_busy === 0, "R7 ends without stop", nstop - s0, 0);
        clr_flags(7'h7f);
      end
    end
    card_busy = 0;

    // R5 token sweep
    for (int t = 0; t < 32; t++) begin
      card_tok = 5'(t);
      push_bytes(1, t);
      start_cmd(0, 1, 1);
      pulse(3);
      wait_idle();
      chk(flags[5] === (t != 5), "R5 token error flag", int'(flags[5]), t != 5);
      chk(flags[1] === (t == 5) && busy === 0, "R5 accept only 00101", int'(flags[1]), t == 5);
      clr_flags(7'h7f);
    end
    card_tok = 5'b00101;

    // R6 busy timeout boundary
    card_busy = TMO - 1;
    push_bytes(2, 3);
    start_cmd(0, 2, 1);
    pulse(3);
    wait_idle();
    chk(flags === 7'b0010010, "R6 busy just under timeout", int'(flags), 18);
    clr_flags(7'h7f);
    card_busy = TMO;
    push_bytes(2, 4);
    start_cmd(0, 2, 1);
    pulse(3);
    wait_idle();
    chk(flags === 7'b1000000, "R6 busy timeout flag", int'(flags), 64);
    chk(busy === 0, "R6 timeout ends sequence", int'(busy), 0);
    repeat (TMO + 10) @(negedge clk);
    clr_flags(7'h7f);
    card_busy = 1;

    // R9 preset sweep
    for (int L = 1; L <= 3; L++) begin
      for (int c = 1; c <= 3; c++) begin
        f0 = nframes; s0 = nstop;
        push_bytes(L*c, 9 + L + c);
        start_cmd(2, L, c);
        pulse(3);
        wait_idle();
        chk(nframes == f0 + c, "R9 preset block count", nframes - f0, c);
        chk((flags & 7'b0001110) === 7'b0001000, "R9 count-done flag only", int'(flags & 7'b0001110), 8);
        chk(nstop == s0, "R9 no stop request", nstop - s0, 0);
        clr_flags(7'h7f);
      end
    end

    // R8 open-ended
    f0 = nframes; s0 = nstop;
    push_bytes(6, 21);
    start_cmd(1, 2, 0);
    pulse(3);
    for (int k = 0; k < 3; k++) begin
      wait_flag(1);
      repeat (5) @(negedge clk);
      chk(nframes == f0 + k + 1, "R8 pause after each block", nframes - f0, k + 1);
      chk(busy === 1 && dat_oe === 0, "R8 paused and still busy", int'(busy), 1);
      clr_flags(7'h02);
      if (k < 2) pulse(3);
    end
    pulse(4);
    @(negedge clk);
    chk(nstop == s0 + 1, "R8 one stop pulse", nstop - s0, 1);
    chk(busy === 0, "R8 stop ends sequence", int'(busy), 0);
    clr_flags(7'h7f);

    // R10 suspend on short FIFO, retry, resume
    f0 = nframes; s0 = nstop;
    push_bytes(4, 30);
    start_cmd(2, 2, 3);
    pulse(3);
    wait_flag(2);
    repeat (3) @(negedge clk);
    chk(nframes == f0 + 2 && busy === 1, "R10 suspended after two blocks", nframes - f0, 2);
    chk(flags[3] === 0, "R10 no count-done while suspended", int'(flags[3]), 0);
    clr_flags(7'h04);
    pulse(3);
    repeat (3) @(negedge clk);
    chk(flags[2] === 1 && nframes == f0 + 2, "R10 retry while short", int'(flags[2]), 1);
    clr_flags(7'h04);
    push_bytes(2, 31);
    pulse(3);
    wait_idle();
    chk(nframes == f0 + 3 && flags[3] === 1, "R10 resume completes", nframes - f0, 3);
    chk(nstop == s0, "R10 no stop on completion", nstop - s0, 0);
    clr_flags(7'h7f);

    // R10 stop from suspension
    f0 = nframes; s0 = nstop;
    push_bytes(1, 40);
    start_cmd(2, 1, 3);
    pulse(3);
    wait_flag(2);
    pulse(4);
    @(negedge clk);
    chk(nstop == s0 + 1 && busy === 0, "R10 stop from suspend", nstop - s0, 1);
    chk(flags[3] === 0 && nframes == f0 + 1, "R10 no count-done after stop", int'(flags[3]), 0);
    clr_flags(7'h7f);

    // R13 FIFO clear
    push_bytes(3, 50);
    pulse(5);
    exp_q.delete();
    f0 = nframes;
    start_cmd(0, 1, 1);
    pulse(3);
    repeat (3) @(negedge clk);
    chk(flags[2] === 1 && nframes == f0, "R13 idle clear empties FIFO", int'(flags[2]), 1);
    pulse(4);
    clr_flags(7'h7f);
    push_bytes(1, 51);
    start_cmd(0, 1, 1);
    pulse(5);
    pulse(3);
    wait_idle();
    chk(nframes == f0 + 1 && flags[1] === 1, "R13 clear ignored when not idle", nframes - f0, 1);
    clr_flags(7'h7f);

    // R12 sticky and per-bit clear
    card_busy = 2;
    push_bytes(1, 60);
    start_cmd(0, 1, 1);
    pulse(3);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(flags === 7'b0010010, "R12 flags held", int'(flags), 18);
    clr_flags(7'b0000010);
    chk(flags === 7'b0010000, "R12 single bit cleared", int'(flags), 16);
    clr_flags(7'h7f);
    chk(exp_q.size() == 0, "R4 all queued bytes sent", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule